// File: doc/BRIEF.md
# Operand Addressing Mode Decoder

This block turns the 6-bit operand field of a 16-bit word machine into an effective location. A single code space covers several kinds of location: general registers, memory reached through a register or through a word that follows the instruction, the stack with push, pop and peek, the stack pointer, the program counter, the overflow register, and small literals. The block owns the stack pointer and the program counter and steps them as each mode demands.

An instruction sequencer puts a code on `code` and pulses `start`. The decoder answers with a one-cycle `done` strobe together with a location kind, a selector and a data word. For memory kinds the data word is an address. For registers it is the register's value, and for literals it is the value itself. Modes that consume the following instruction word raise `mem_rd` for one cycle, with the program counter on `mem_addr`. The word at that address has to appear on `mem_rdata` in the same cycle, so the read port is combinational. Any literal location raises `loc_lit`, and a write stage then discards writes to it. The register inputs `gpr_in` and `ovf_in` must stay steady while a decode is in progress.

Top module: `opnd_decode`

## Requirements
- R1: Codes 0x00..0x07 give kind 0 (register), with selector = code & 7 and data = the value of that register. Registers are packed in `gpr_in` in the order A, B, C, X, Y, Z, I, J, with register n at bits [16n+15:16n].
- R2: Codes 0x08..0x0f give kind 1 (memory), with selector = code & 7 and data = the value of register (code & 7), used as the address.
- R3: Codes 0x10..0x17 read the word at the current PC and advance PC by one. They then give kind 1 with selector = code & 7 and address = word + register (code & 7) modulo 2^16.
- R4: Code 0x18 gives kind 1 with address = SP, then SP increases by one.
- R5: Code 0x19 gives kind 1 with address = SP and leaves SP unchanged.
- R6: Code 0x1a first lowers SP by one (modulo 2^16), then gives kind 1 with address = the new SP.
- R7: Codes 0x1b, 0x1c and 0x1d give kind 2 (special) with selector 0, 1 or 2 and data = the current SP, PC or `ovf_in`. SP and PC are left unchanged.
- R8: Code 0x1e reads the word at PC, advances PC by one, and gives kind 1 with that word as the address.
- R9: Code 0x1f reads the word at PC, advances PC by one, and gives kind 3 (literal) with that word as data.
- R10: Codes 0x20..0x3f give kind 3 with data = code − 0x20.
- R11: `loc_lit` is 1 at `done` exactly when the kind is 3.
- R12: `done` comes one cycle after an accepted `start` for modes that read no extra word, and two cycles after for modes that do. In the two-cycle case `mem_rd` is high only in the cycle between, and `mem_addr` then holds the PC from before the step.
- R13: A `start` that arrives while an extra-word read is under way is ignored. It produces no `done` and moves neither SP nor PC.
- R14: Reset (synchronous, active high) clears SP, PC, `done` and `mem_rd` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin decoding `code` |
| code | input | 6 | Operand field |
| gpr_in | input | 128 | Eight general registers, register n at [16n+15:16n] |
| ovf_in | input | 16 | Overflow register value |
| mem_rdata | input | 16 | Word at `mem_addr`, valid in the same cycle |
| mem_addr | output | 16 | Extra-word read address |
| mem_rd | output | 1 | Extra-word read in progress |
| done | output | 1 | Result valid, one cycle |
| loc_kind | output | 2 | 0 register, 1 memory, 2 special, 3 literal |
| loc_sel | output | 3 | Register index or special selector |
| loc_data | output | 16 | Address, register value or literal |
| loc_lit | output | 1 | Destination is a literal |
| sp | output | 16 | Stack pointer |
| pc | output | 16 | Program counter |

## Verification
For each code the driver works out one or two cycles of latency. It records the edge that accepts `start`, and the monitor checks that `done` is seen on the falling edge exactly one edge later, or two edges later for extra-word modes. SP and PC are compared at that same falling edge, after the pointer step has taken effect. On the falling edge between the two edges of an extra-word decode, the driver checks `mem_rd` and `mem_addr` directly. It also drives a second `start` there to show that the request is dropped.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  localparam int CODE_W = 6;

  typedef enum logic [1:0] {K_GPR = 2'd0, K_MEM = 2'd1, K_SPC = 2'd2, K_LIT = 2'd3} loc_kind_e;

  typedef enum logic [3:0] {
    M_REG, M_IND, M_IDX, M_POP, M_PEEK, M_PUSH,
    M_SPR, M_PCR, M_OVR, M_NWA, M_NWL, M_SLIT
  } mode_e;

  localparam logic [2:0] SEL_SP = 3'd0;
  localparam logic [2:0] SEL_PC = 3'd1;
  localparam logic [2:0] SEL_OV = 3'd2;

  function automatic mode_e classify(input logic [CODE_W-1:0] c);
    mode_e m;
    if (c[5])                m = M_SLIT;
    else if (c[4:3] == 2'b00) m = M_REG;
    else if (c[4:3] == 2'b01) m = M_IND;
    else if (c[4:3] == 2'b10) m = M_IDX;
    else begin
      case (c[2:0])
        3'd0:    m = M_POP;
        3'd1:    m = M_PEEK;
        3'd2:    m = M_PUSH;
        3'd3:    m = M_SPR;
        3'd4:    m = M_PCR;
        3'd5:    m = M_OVR;
        3'd6:    m = M_NWA;
        default: m = M_NWL;
      endcase
    end
    return m;
  endfunction
endpackage

// File: rtl/opnd_class.sv
module opnd_class
  import opnd_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output mode_e             mode,
  output logic              needs_word,
  output logic [2:0]        ridx
);
  always_comb begin
    mode       = classify(code);
    needs_word = (mode == M_IDX) || (mode == M_NWA) || (mode == M_NWL);
    ridx       = code[2:0];
  end
endmodule

// File: rtl/opnd_gpr_mux.sv
module opnd_gpr_mux #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [NREG*DW-1:0] gpr_flat,
  input  logic [IW-1:0]      idx,
  output logic [DW-1:0]      val
);
  logic [DW-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign bank[g] = gpr_flat[g*DW +: DW];
  end

  assign val = bank[idx];
endmodule

// File: rtl/opnd_ptrs.sv
module opnd_ptrs #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sp_up,
  input  logic          sp_dn,
  input  logic          pc_up,
  output logic [DW-1:0] sp,
  output logic [DW-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
      pc <= '0;
    end else begin
      if (sp_up)      sp <= sp + 1'b1;
      else if (sp_dn) sp <= sp - 1'b1;
      if (pc_up)      pc <= pc + 1'b1;
    end
  end

  // R4 R6: the stack pointer moves by at most one per cycle
  a_r4_sp_unit_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sp == $past(sp) || sp == $past(sp) + 1'b1 || sp == $past(sp) - 1'b1));

  // R14: reset clears both pointers
  a_r14_ptr_reset: assert property (@(posedge clk) rst |=> (sp == '0 && pc == '0));
endmodule

// File: rtl/opnd_decode.sv
module opnd_decode
  import opnd_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CODE_W-1:0] code,
  input  logic [NREG*DW-1:0] gpr_in,
  input  logic [DW-1:0]     ovf_in,
  input  logic [DW-1:0]     mem_rdata,
  output logic [DW-1:0]     mem_addr,
  output logic              mem_rd,
  output logic              done,
  output logic [1:0]        loc_kind,
  output logic [2:0]        loc_sel,
  output logic [DW-1:0]     loc_data,
  output logic              loc_lit,
  output logic [DW-1:0]     sp,
  output logic [DW-1:0]     pc
);
  typedef enum logic {S_IDLE, S_WORD} state_e;
  state_e st;

  mode_e      mode, mode_q;
  logic       needs_word;
  logic [2:0] ridx, ridx_q;
  logic [IW-1:0] mux_idx;
  logic [DW-1:0] gpr_val;
  logic       accept;

  opnd_class u_class (.code(code), .mode(mode), .needs_word(needs_word), .ridx(ridx));

  assign mux_idx = IW'((st == S_WORD) ? ridx_q : ridx);

  opnd_gpr_mux #(.DW(DW), .NREG(NREG)) u_mux (
    .gpr_flat(gpr_in), .idx(mux_idx), .val(gpr_val)
  );

  assign accept = start && (st == S_IDLE);

  opnd_ptrs #(.DW(DW)) u_ptrs (
    .clk(clk), .rst(rst),
    .sp_up(accept && mode == M_POP),
    .sp_dn(accept && mode == M_PUSH),
    .pc_up(accept && needs_word),
    .sp(sp), .pc(pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      mode_q   <= M_REG;
      ridx_q   <= '0;
      mem_addr <= '0;
      mem_rd   <= 1'b0;
      done     <= 1'b0;
      loc_kind <= K_GPR;
      loc_sel  <= '0;
      loc_data <= '0;
      loc_lit  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (needs_word) begin
            st       <= S_WORD;
            mode_q   <= mode;
            ridx_q   <= ridx;
            mem_addr <= pc;
            mem_rd   <= 1'b1;
          end else begin
            done    <= 1'b1;
            loc_lit <= 1'b0;
            loc_sel <= '0;
            case (mode)
              M_REG:  begin loc_kind <= K_GPR; loc_sel <= ridx; loc_data <= gpr_val; end
              M_IND:  begin loc_kind <= K_MEM; loc_sel <= ridx; loc_data <= gpr_val; end
              M_POP,
              M_PEEK: begin loc_kind <= K_MEM; loc_data <= sp; end
              M_PUSH: begin loc_kind <= K_MEM; loc_data <= sp - 1'b1; end
              M_SPR:  begin loc_kind <= K_SPC; loc_sel <= SEL_SP; loc_data <= sp; end
              M_PCR:  begin loc_kind <= K_SPC; loc_sel <= SEL_PC; loc_data <= pc; end
              M_OVR:  begin loc_kind <= K_SPC; loc_sel <= SEL_OV; loc_data <= ovf_in; end
              default: begin
                loc_kind <= K_LIT;
                loc_lit  <= 1'b1;
                loc_data <= DW'(code[4:0]);
              end
            endcase
          end
        end
        S_WORD: begin
          st      <= S_IDLE;
          mem_rd  <= 1'b0;
          done    <= 1'b1;
          loc_lit <= 1'b0;
          loc_sel <= '0;
          case (mode_q)
            M_IDX: begin loc_kind <= K_MEM; loc_sel <= ridx_q; loc_data <= mem_rdata + gpr_val; end
            M_NWA: begin loc_kind <= K_MEM; loc_data <= mem_rdata; end
            default: begin loc_kind <= K_LIT; loc_lit <= 1'b1; loc_data <= mem_rdata; end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11: literal flag agrees with the literal kind
  a_r11_lit_kind: assert property (@(posedge clk) disable iff (rst)
    done |-> (loc_lit == (loc_kind == K_LIT)));

  // R12: an extra-word read lasts one cycle and is followed by done
  a_r12_rd_then_done: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> (done && !mem_rd));

  // R12 R3: the read address is the PC from before its step
  a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd) |-> (pc == mem_addr + 1'b1));

  // R13: pointers hold still while the extra word is being read
  a_r13_hold_in_read: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> ($stable(pc) && $stable(sp)));

  // R14: reset clears the strobes
  a_r14_strobe_reset: assert property (@(posedge clk) rst |=> (!done && !mem_rd));
endmodule

// File: tb/opnd_decode_test.sv
module opnd_decode_test;
  localparam int CLK_HALF = 5;
  localparam int DW = 16;
  localparam int NREG = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [5:0] code = '0;
  logic [NREG*DW-1:0] gpr_in;
  logic [DW-1:0] ovf_in = 16'h5A5A;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] mem_addr, loc_data, sp, pc;
  logic mem_rd, done, loc_lit;
  logic [1:0] loc_kind;
  logic [2:0] loc_sel;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;

  typedef struct {
    int          due;
    logic [1:0]  kind;
    logic [2:0]  sel;
    logic [15:0] data;
    logic [15:0] sp_e;
    logic [15:0] pc_e;
    string       req;
  } exp_t;
  exp_t sbq[$];

  logic [15:0] sp_m = 16'h0000;
  logic [15:0] pc_m = 16'h0000;

  opnd_decode uut (
    .clk(clk), .rst(rst), .start(start), .code(code), .gpr_in(gpr_in),
    .ovf_in(ovf_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .done(done), .loc_kind(loc_kind), .loc_sel(loc_sel), .loc_data(loc_data),
    .loc_lit(loc_lit), .sp(sp), .pc(pc)
  );

  always #CLK_HALF clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] word_at(input logic [15:0] a);
    return 16'h0100 * {10'd0, a[5:0]} + 16'h0020;
  endfunction

  function automatic logic [15:0] reg_val(input int n);
    return (n == 7) ? 16'hFFF0 : 16'h1111 * (n + 1);
  endfunction

  assign mem_rdata = word_at(mem_addr);

  initial begin
    for (int n = 0; n < NREG; n++) gpr_in[n*DW +: DW] = reg_val(n);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: works out the expected result, pushes it, then drives the stimulus
  task automatic issue(input logic [5:0] c, input string req, input bit poke_busy = 0);
    exp_t e;
    bit word;
    logic [15:0] w;
    logic [15:0] pc0;
    word = (c[5:3] == 3'b010) || (c == 6'h1e) || (c == 6'h1f);
    pc0 = pc_m;
    e.sel = 3'd0;
    e.req = req;
    if (word) begin
      w = word_at(pc_m);
      pc_m = pc_m + 1;
    end
    if (c >= 6'h20) begin e.kind = 2'd3; e.data = {11'd0, c[4:0]}; end
    else if (c < 6'h08) begin e.kind = 2'd0; e.sel = c[2:0]; e.data = reg_val(c[2:0]); end
    else if (c < 6'h10) begin e.kind = 2'd1; e.sel = c[2:0]; e.data = reg_val(c[2:0]); end
    else if (c < 6'h18) begin e.kind = 2'd1; e.sel = c[2:0]; e.data = w + reg_val(c[2:0]); end
    else case (c)
      6'h18: begin e.kind = 2'd1; e.data = sp_m; sp_m = sp_m + 1; end
      6'h19: begin e.kind = 2'd1; e.data = sp_m; end
      6'h1a: begin sp_m = sp_m - 1; e.kind = 2'd1; e.data = sp_m; end
      6'h1b: begin e.kind = 2'd2; e.sel = 3'd0; e.data = sp_m; end
      6'h1c: begin e.kind = 2'd2; e.sel = 3'd1; e.data = pc_m; end
      6'h1d: begin e.kind = 2'd2; e.sel = 3'd2; e.data = ovf_in; end
      6'h1e: begin e.kind = 2'd1; e.data = w; end
      default: begin e.kind = 2'd3; e.data = w; end
    endcase
    e.sp_e = sp_m;
    e.pc_e = pc_m;
    @(negedge clk);
    code = c;
    start = 1'b1;
    e.due = cyc + 1 + (word ? 1 : 0);
    sbq.push_back(e);
    @(negedge clk);
    start = 1'b0;
    if (word) begin
      check({"R12 mem_rd ", req}, {31'd0, mem_rd}, 32'd1);
      check({"R12 mem_addr ", req}, {16'd0, mem_addr}, {16'd0, pc0});
      if (poke_busy) begin
        code = 6'h18; // R13: a pop request while busy must be dropped
        start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
    end
    @(negedge clk);
  endtask

  // monitor: pops and compares at every done
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        if (sbq.size() == 0) begin
          check("R13 unexpected done", 32'd1, 32'd0);
        end else begin
          e = sbq.pop_front();
          check({"R12 latency ", e.req}, cyc, e.due);
          check({e.req, " kind"}, {30'd0, loc_kind}, {30'd0, e.kind});
          check({e.req, " sel"}, {29'd0, loc_sel}, {29'd0, e.sel});
          check({e.req, " data"}, {16'd0, loc_data}, {16'd0, e.data});
          check({"R11 lit ", e.req}, {31'd0, loc_lit}, {31'd0, (e.kind == 2'd3)});
          check({e.req, " sp"}, {16'd0, sp}, {16'd0, e.sp_e});
          check({e.req, " pc"}, {16'd0, pc}, {16'd0, e.pc_e});
        end
      end
    end
  end

  initial begin
    repeat (500000) @(posedge clk);
    check("watchdog expired", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R14: reset state
    check("R14 sp", {16'd0, sp}, 32'd0);
    check("R14 pc", {16'd0, pc}, 32'd0);
    check("R14 done", {31'd0, done}, 32'd0);
    check("R14 mem_rd", {31'd0, mem_rd}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    for (int c = 0; c < 8; c++) issue(6'(c), "R1");
    for (int c = 8; c < 16; c++) issue(6'(c), "R2");
    issue(6'h10, "R3");
    issue(6'h17, "R3 wrap");
    issue(6'h13, "R3");
    issue(6'h1a, "R6 wrap");
    issue(6'h1a, "R6");
    issue(6'h19, "R5");
    issue(6'h18, "R4");
    issue(6'h18, "R4 wrap");
    issue(6'h1b, "R7 sp");
    issue(6'h1c, "R7 pc");
    issue(6'h1d, "R7 ovf");
    issue(6'h1e, "R8");
    issue(6'h1f, "R9");
    issue(6'h20, "R10 low");
    issue(6'h3f, "R10 high");
    issue(6'h2a, "R10");
    issue(6'h1e, "R13 busy", 1'b1);
    issue(6'h1b, "R13 sp after");
    issue(6'h1c, "R13 pc after");
    repeat (4) @(negedge clk);
    check("R13 queue drained", sbq.size(), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule